// File: doc/BRIEF.md
# Memory Access Port Block Transfer Engine

This engine turns one block transfer command into a sequence of register accesses on a memory access port. The command carries a start address, an element size of 1, 2 or 4 bytes, an element count, a direction and an address-increment flag. For every data beat the engine first writes the control/status word (CSW), then the transfer address register (TAR), and then makes one access to the data read/write register (DRW). Write data is taken one byte at a time from a local show-ahead byte FIFO. Read data is pushed one byte at a time into a local byte sink.

Each byte is steered by the low two bits of its own address. It sits on lane `(addr + i) & 3` of the 32-bit DRW word, where `i` is the byte's position within the beat. When increment is enabled, packing is enabled, at least four bytes remain, and at least four bytes are left before the auto-increment block boundary, a narrow transfer is upgraded to one packed 32-bit beat. Otherwise each beat moves exactly one element.

If an access fails, the engine reads TAR back and reports the failing address. It limits the reported byte count to the smaller of the bytes already moved and that address minus the start.

The state machine has these states:
- IDLE: accepts a command, then goes to DONE on a rejection or a zero count, or to PLAN.
- PLAN: sizes the next beat, then goes to GATHER for writes or CSW for reads.
- GATHER: pops the beat's bytes, then goes to CSW.
- CSW, TAR and DRW: each waits for an acknowledge. An error on any of them goes to TARBACK.
- After DRW the engine goes to SCATTER for reads or STEP for writes.
- SCATTER: pushes the beat's bytes, then goes to STEP.
- STEP: advances the counters, then goes to PLAN or DONE.
- TARBACK: reads TAR, then goes to DONE.
- DONE: holds for one cycle, then returns to IDLE.

Top module: `memap_xfer_engine`

## Requirements
- R1: An element size of 1, 2 or 4 bytes puts size code 0, 1 or 2 into CSW bits [2:0]. Any other size finishes with status UNALIGNED (code 1) and makes no port access.
- R2: With `UNALIGNED_BAD` set, a 2-byte element at an odd address or a 4-byte element at an address with nonzero bits [1:0] finishes with UNALIGNED and makes no port access.
- R3: Every DRW access (register index 3) comes directly after a CSW write (index 0) followed by a TAR write (index 1).
- R4: On writes, the byte at address `a` is placed on lane `a & 3` (bits `8*(a&3)+7 : 8*(a&3)`) of the DRW word. Lanes not carrying a byte of the beat are zero.
- R5: On reads, the byte for address `a` is taken from lane `a & 3` of the returned word, and bytes reach the sink in address order.
- R6: A packed beat moves 4 bytes with CSW bits [5:4] = 2. It is used only when increment is on, at least 4 bytes remain, and `BLOCK_BYTES - (addr mod BLOCK_BYTES) >= 4`.
- R7: Near an auto-increment block boundary, elements go one per beat until the boundary is crossed, after which packing resumes.
- R8: With increment off, CSW bits [5:4] = 0, every TAR write carries the start address, and each beat moves one element.
- R9: A non-packed incrementing beat uses CSW bits [5:4] = 1, and the address advances by the bytes moved.
- R10: Completion raises `done` for exactly one cycle, with status OK (code 0) and `xfer_bytes` equal to count times size. A zero count finishes OK with no port access.
- R11: An error response ends the transfer with status BUS_ERROR (code 2). TAR is read back into `fail_addr`, and `xfer_bytes = min(bytes moved, fail_addr - start)`.
- R12: Only one of FIFO pop, sink push and port request is active in any cycle. When the FIFO is empty, a write waits and issues no DRW access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start a command (taken in IDLE) |
| cmd_addr | input | 32 | Start byte address |
| cmd_size | input | 3 | Element size in bytes |
| cmd_count | input | CNT_W | Number of elements |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_incr | input | 1 | 1 = increment the address |
| src_empty | input | 1 | Write FIFO is empty |
| src_data | input | 8 | Head byte of the write FIFO |
| src_pop | output | 1 | Take the head byte |
| snk_push | output | 1 | Read byte valid |
| snk_data | output | 8 | Read byte |
| ap_req | output | 1 | Port access request, held until ack |
| ap_wr | output | 1 | 1 = register write |
| ap_reg | output | 2 | Register index: 0 CSW, 1 TAR, 3 DRW |
| ap_wdata | output | 32 | Register write data |
| ap_ack | input | 1 | Access complete |
| ap_err | input | 1 | Access failed (valid with ack) |
| ap_rdata | input | 32 | Register read data (valid with ack) |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 UNALIGNED, 2 BUS_ERROR |
| fail_addr | output | 32 | Address read back after an error |
| xfer_bytes | output | CNT_W+2 | Bytes delivered |

## Verification
The assertions check on every cycle:
- the one-cycle `done` pulse;
- the TAR-before-DRW order;
- that a packed CSW always goes with a 4-byte beat and enough remaining bytes;
- that the address stays frozen when increment is off;
- that the byte counter never underflows;
- that pop, push and request never overlap.

The bench scenarios are the only way to show lane placement and zero lanes, read byte order, the exact beat split at a block boundary, the rejection cases, and the clipped byte count after a bus error. All of these are checked against a byte-level port model that holds its own memory.

// File: rtl/memap_pkg.sv
package memap_pkg;
    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_UNALIGNED = 2'd1,
        ST_BUS_ERR   = 2'd2
    } xfer_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PLAN, S_GATHER, S_CSW, S_TAR, S_DRW,
        S_SCATTER, S_STEP, S_TARBACK, S_DONE
    } eng_state_e;

    localparam logic [1:0] REG_CSW = 2'd0;
    localparam logic [1:0] REG_TAR = 2'd1;
    localparam logic [1:0] REG_DRW = 2'd3;

    localparam logic [1:0] INC_OFF    = 2'd0;
    localparam logic [1:0] INC_SINGLE = 2'd1;
    localparam logic [1:0] INC_PACKED = 2'd2;
endpackage

// File: rtl/memap_size_check.sv
module memap_size_check (
    input  logic [2:0] size,
    input  logic [1:0] addr_lo,
    output logic       legal,
    output logic [1:0] code,
    output logic       misaligned
);
    always_comb begin
        legal      = 1'b1;
        code       = 2'd0;
        misaligned = 1'b0;
        unique case (size)
            3'd1: code = 2'd0;
            3'd2: begin code = 2'd1; misaligned = addr_lo[0]; end
            3'd4: begin code = 2'd2; misaligned = |addr_lo; end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/memap_beat_plan.sv
module memap_beat_plan #(
    parameter int BLOCK_BYTES = 1024,
    parameter int PACKED_EN   = 1,
    parameter int BYTES_W     = 18,
    localparam int BLK_W      = $clog2(BLOCK_BYTES)
) (
    input  logic [BLK_W-1:0]   addr_lo,
    input  logic [BYTES_W-1:0] remaining,
    input  logic [1:0]         size_code,
    input  logic               incr,
    output logic [2:0]         beat,
    output logic [31:0]        csw
);
    import memap_pkg::*;

    logic [BLK_W:0] room;
    logic           packed_ok;
    logic [1:0]     inc_mode;

    always_comb begin
        room      = (BLK_W+1)'(BLOCK_BYTES) - {1'b0, addr_lo};
        packed_ok = incr && (PACKED_EN != 0) && (remaining >= BYTES_W'(4))
                    && (room >= (BLK_W+1)'(4));
        beat      = packed_ok ? 3'd4 : (3'd1 << size_code);
        inc_mode  = !incr ? INC_OFF : (packed_ok ? INC_PACKED : INC_SINGLE);
        csw       = {26'd0, inc_mode, 2'b00, size_code};
    end
endmodule

// File: rtl/memap_lane.sv
module memap_lane (
    input  logic [31:0] word_in,
    input  logic [1:0]  lane,
    input  logic [7:0]  byte_in,
    output logic [31:0] word_out,
    output logic [7:0]  byte_out
);
    always_comb begin
        word_out = word_in;
        word_out[8*lane +: 8] = byte_in;
        byte_out = word_in[8*lane +: 8];
    end
endmodule

// File: rtl/memap_xfer_engine.sv
module memap_xfer_engine #(
    parameter int CNT_W         = 16,
    parameter int BLOCK_BYTES   = 1024,
    parameter int PACKED_EN     = 1,
    parameter int UNALIGNED_BAD = 1,
    localparam int BYTES_W      = CNT_W + 2,
    localparam int BLK_W        = $clog2(BLOCK_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [31:0]        cmd_addr,
    input  logic [2:0]         cmd_size,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic               cmd_write,
    input  logic               cmd_incr,
    input  logic               src_empty,
    input  logic [7:0]         src_data,
    output logic               src_pop,
    output logic               snk_push,
    output logic [7:0]         snk_data,
    output logic               ap_req,
    output logic               ap_wr,
    output logic [1:0]         ap_reg,
    output logic [31:0]        ap_wdata,
    input  logic               ap_ack,
    input  logic               ap_err,
    input  logic [31:0]        ap_rdata,
    output logic               done,
    output logic [1:0]         status,
    output logic [31:0]        fail_addr,
    output logic [BYTES_W-1:0] xfer_bytes
);
    import memap_pkg::*;

    eng_state_e   state, nxt;
    logic [31:0]  cur_addr, start_q, csw_q, word_q, span;
    logic [BYTES_W-1:0] remaining, moved, total;
    logic [2:0]   beat_q, k, plan_beat;
    logic [1:0]   code_q, sz_code, lane;
    logic         wr_q, incr_q, sz_legal, sz_mis, reject;
    logic [31:0]  plan_csw, lane_word;
    logic [7:0]   lane_byte;
    xfer_status_e stat_q;

    memap_size_check u_size (
        .size(cmd_size), .addr_lo(cmd_addr[1:0]),
        .legal(sz_legal), .code(sz_code), .misaligned(sz_mis)
    );

    memap_beat_plan #(.BLOCK_BYTES(BLOCK_BYTES), .PACKED_EN(PACKED_EN), .BYTES_W(BYTES_W)) u_plan (
        .addr_lo(cur_addr[BLK_W-1:0]), .remaining(remaining), .size_code(code_q),
        .incr(incr_q), .beat(plan_beat), .csw(plan_csw)
    );

    assign lane = cur_addr[1:0] + k[1:0];

    memap_lane u_lane (
        .word_in(word_q), .lane(lane), .byte_in(src_data),
        .word_out(lane_word), .byte_out(lane_byte)
    );

    assign total  = BYTES_W'(cmd_count) << sz_code;
    assign reject = !sz_legal || ((UNALIGNED_BAD != 0) && sz_mis);
    assign span   = ap_rdata - start_q;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (cmd_valid) nxt = (reject || total == '0) ? S_DONE : S_PLAN;
            S_PLAN:    nxt = wr_q ? S_GATHER : S_CSW;
            S_GATHER:  if (!src_empty && k == beat_q - 3'd1) nxt = S_CSW;
            S_CSW:     if (ap_ack) nxt = ap_err ? S_TARBACK : S_TAR;
            S_TAR:     if (ap_ack) nxt = ap_err ? S_TARBACK : S_DRW;
            S_DRW:     if (ap_ack) nxt = ap_err ? S_TARBACK : (wr_q ? S_STEP : S_SCATTER);
            S_SCATTER: if (k == beat_q - 3'd1) nxt = S_STEP;
            S_STEP:    nxt = (remaining == BYTES_W'(beat_q)) ? S_DONE : S_PLAN;
            S_TARBACK: if (ap_ack) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0; start_q <= '0; csw_q <= '0; word_q <= '0;
            remaining <= '0; moved <= '0; beat_q <= 3'd1; k <= '0;
            code_q <= '0; wr_q <= 1'b0; incr_q <= 1'b0;
            stat_q <= ST_OK; fail_addr <= '0; xfer_bytes <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    cur_addr   <= cmd_addr;
                    start_q    <= cmd_addr;
                    remaining  <= total;
                    moved      <= '0;
                    code_q     <= sz_code;
                    wr_q       <= cmd_write;
                    incr_q     <= cmd_incr;
                    stat_q     <= reject ? ST_UNALIGNED : ST_OK;
                    fail_addr  <= '0;
                    xfer_bytes <= '0;
                end
                S_PLAN: begin
                    beat_q <= plan_beat;
                    csw_q  <= plan_csw;
                    k      <= '0;
                    word_q <= '0;
                end
                S_GATHER: if (!src_empty) begin
                    word_q <= lane_word;
                    k      <= k + 3'd1;
                end
                S_DRW: if (ap_ack && !ap_err && !wr_q) word_q <= ap_rdata;
                S_SCATTER: k <= k + 3'd1;
                S_STEP: begin
                    remaining <= remaining - BYTES_W'(beat_q);
                    moved     <= moved + BYTES_W'(beat_q);
                    if (incr_q) cur_addr <= cur_addr + 32'(beat_q);
                    if (remaining == BYTES_W'(beat_q)) xfer_bytes <= moved + BYTES_W'(beat_q);
                end
                S_TARBACK: if (ap_ack) begin
                    stat_q <= ST_BUS_ERR;
                    if (!ap_err) begin
                        fail_addr  <= ap_rdata;
                        xfer_bytes <= (span < 32'(moved)) ? BYTES_W'(span) : moved;
                    end else begin
                        fail_addr  <= cur_addr;
                        xfer_bytes <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ap_req   = 1'b0;
        ap_wr    = 1'b0;
        ap_reg   = REG_CSW;
        ap_wdata = '0;
        src_pop  = 1'b0;
        snk_push = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_GATHER:  src_pop = !src_empty;
            S_CSW:     begin ap_req = 1'b1; ap_wr = 1'b1; ap_reg = REG_CSW; ap_wdata = csw_q; end
            S_TAR:     begin ap_req = 1'b1; ap_wr = 1'b1; ap_reg = REG_TAR; ap_wdata = cur_addr; end
            S_DRW:     begin ap_req = 1'b1; ap_wr = wr_q; ap_reg = REG_DRW;
                             ap_wdata = wr_q ? word_q : 32'd0; end
            S_SCATTER: snk_push = 1'b1;
            S_TARBACK: begin ap_req = 1'b1; ap_reg = REG_TAR; end
            S_DONE:    done = 1'b1;
            default: ;
        endcase
    end

    assign snk_data = lane_byte;
    assign status   = stat_q;

    logic drw_req, tar_wr_req;
    assign drw_req    = ap_req && ap_reg == REG_DRW;
    assign tar_wr_req = ap_req && ap_wr && ap_reg == REG_TAR;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R3
    tar_before_drw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drw_req) |-> $past(tar_wr_req));
    // R6
    packed_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tar_wr_req && csw_q[5:4] == INC_PACKED) |-> (beat_q == 3'd4 && remaining >= BYTES_W'(4)));
    // R8
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP && !incr_q) |=> $stable(cur_addr));
    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP) |-> (remaining >= BYTES_W'(beat_q)));
    // R12
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_pop, snk_push, ap_req}));
    // R11
    err_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_BUS_ERR) |-> (xfer_bytes <= moved));
endmodule

// File: tb/test_memap_xfer_engine.sv
module test_memap_xfer_engine;
    localparam int CNT_W = 16;
    localparam int BW    = CNT_W + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cmd_valid = 0, cmd_write = 0, cmd_incr = 0;
    logic [31:0] cmd_addr = 0;
    logic [2:0] cmd_size = 0;
    logic [CNT_W-1:0] cmd_count = 0;
    logic src_empty, src_pop, snk_push, ap_req, ap_wr, done;
    logic [7:0] src_data, snk_data;
    logic [1:0] ap_reg, status;
    logic [31:0] ap_wdata, ap_rdata, fail_addr;
    logic ap_ack, ap_err;
    logic [BW-1:0] xfer_bytes;

    memap_xfer_engine #(.CNT_W(CNT_W), .BLOCK_BYTES(64)) i_memap_xfer_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_count(cmd_count), .cmd_write(cmd_write),
        .cmd_incr(cmd_incr), .src_empty(src_empty), .src_data(src_data),
        .src_pop(src_pop), .snk_push(snk_push), .snk_data(snk_data),
        .ap_req(ap_req), .ap_wr(ap_wr), .ap_reg(ap_reg), .ap_wdata(ap_wdata),
        .ap_ack(ap_ack), .ap_err(ap_err), .ap_rdata(ap_rdata), .done(done),
        .status(status), .fail_addr(fail_addr), .xfer_bytes(xfer_bytes)
    );

    int checks = 0, errors = 0;

    // byte FIFO source and sink
    logic [7:0] src_q [0:31];
    int src_idx = 0, src_base = 0, src_lim = 0;
    assign src_empty = (src_idx - src_base) >= src_lim;
    assign src_data  = src_q[(src_idx - src_base) & 31];
    logic [7:0] snk_q [0:63];
    int snk_cnt = 0;
    always @(posedge clk) begin
        if (src_pop) src_idx <= src_idx + 1;
        if (snk_push) begin snk_q[snk_cnt & 63] <= snk_data; snk_cnt <= snk_cnt + 1; end
    end

    // port model with byte memory
    logic [7:0] mem [0:255];
    logic [31:0] csw_m, tar_m;
    logic [1:0] last_reg, prev_reg;
    int drw_cnt = 0, order_bad = 0;
    logic [31:0] csw_log [0:63], tar_log [0:63], wd_log [0:63];
    logic err_en = 0, tb_over = 0;
    logic [31:0] err_tar = 0, tb_val = 0;

    always @(posedge clk) begin : model
        logic [31:0] w;
        int nb;
        if (!rst_n) begin
            ap_ack <= 0; ap_err <= 0; ap_rdata <= 0; csw_m <= 0; tar_m <= 0;
            last_reg <= 0; prev_reg <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (ap_req && !ap_ack) begin
            ap_ack <= 1; ap_err <= 0;
            if (ap_reg == 2'd0 && ap_wr) begin
                csw_m <= ap_wdata; prev_reg <= last_reg; last_reg <= 2'd0;
            end else if (ap_reg == 2'd1 && ap_wr) begin
                tar_m <= ap_wdata; prev_reg <= last_reg; last_reg <= 2'd1;
            end else if (ap_reg == 2'd1) begin
                ap_rdata <= tb_over ? tb_val : tar_m;
            end else if (ap_reg == 2'd3) begin
                csw_log[drw_cnt & 63] <= csw_m;
                tar_log[drw_cnt & 63] <= tar_m;
                wd_log[drw_cnt & 63]  <= ap_wdata;
                drw_cnt <= drw_cnt + 1;
                if (!(last_reg == 2'd1 && prev_reg == 2'd0)) order_bad <= order_bad + 1;
                prev_reg <= last_reg; last_reg <= 2'd3;
                nb = (csw_m[5:4] == 2'd2) ? 4 : (1 << csw_m[1:0]);
                if (err_en && tar_m == err_tar) ap_err <= 1;
                else if (ap_wr) begin
                    for (int i = 0; i < nb; i++)
                        mem[(tar_m + i) & 255] <= ap_wdata[8*((tar_m + i) & 3) +: 8];
                end else begin
                    w = 0;
                    for (int i = 0; i < nb; i++)
                        w[8*((tar_m + i) & 3) +: 8] = mem[(tar_m + i) & 255];
                    ap_rdata <= w;
                end
            end
        end else begin
            ap_ack <= 0; ap_err <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    int d0, s0;

    task automatic load_src(input int n);
        @(negedge clk);
        for (int i = 0; i < 32; i++) src_q[i] = 8'(8'hA0 + i);
        src_base = src_idx;
        src_lim  = n;
    endtask

    task automatic run_cmd(input logic [31:0] a, input logic [2:0] sz, input int cnt,
                           input bit wr, input bit inc);
        int t;
        @(negedge clk);
        d0 = drw_cnt; s0 = snk_cnt;
        cmd_addr = a; cmd_size = sz; cmd_count = CNT_W'(cnt);
        cmd_write = wr; cmd_incr = inc; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) chk(0, "R10 done timeout", 0, 1);
    endtask

    task automatic t_reset();
        eq("R10 reset done", done, 0);
        eq("R12 reset req", ap_req, 0);
        eq("R12 reset pop", src_pop, 0);
    endtask

    task automatic t_word_write();
        load_src(12);
        run_cmd(32'h10, 3'd4, 3, 1, 1);
        eq("R10 status", status, 0);
        eq("R10 bytes", xfer_bytes, 12);
        eq("R9 drw count", drw_cnt - d0, 3);
        eq("R1 csw word", csw_log[d0 & 63], 32'h22);
        eq("R9 tar third", tar_log[(d0 + 2) & 63], 32'h18);
        for (int i = 0; i < 12; i++) eq("R4 mem", mem[16 + i], 8'hA0 + 8'(i));
        eq("R3 order", order_bad, 0);
    endtask

    task automatic t_byte_write();
        load_src(6);
        run_cmd(32'h21, 3'd1, 6, 1, 1);
        eq("R6 drw count", drw_cnt - d0, 3);
        eq("R6 csw packed", csw_log[d0 & 63], 32'h20);
        eq("R9 csw single", csw_log[(d0 + 1) & 63], 32'h10);
        eq("R4 packed lanes", wd_log[d0 & 63], 32'hA2A1A0A3);
        eq("R4 zero lanes", wd_log[(d0 + 1) & 63], 32'h0000A400);
        for (int i = 0; i < 6; i++) eq("R4 mem", mem[8'h21 + i], 8'hA0 + 8'(i));
    endtask

    task automatic t_half_read();
        run_cmd(32'h40, 3'd2, 3, 0, 1);
        eq("R5 status", status, 0);
        eq("R5 sink count", snk_cnt - s0, 6);
        eq("R6 drw count", drw_cnt - d0, 2);
        eq("R6 csw packed", csw_log[d0 & 63], 32'h21);
        eq("R1 csw half", csw_log[(d0 + 1) & 63], 32'h11);
        for (int i = 0; i < 6; i++) eq("R5 byte", snk_q[(s0 + i) & 63], 8'((8'h40 + i) * 7 + 3));
    endtask

    task automatic t_no_incr();
        load_src(3);
        run_cmd(32'h33, 3'd1, 3, 1, 0);
        eq("R8 drw count", drw_cnt - d0, 3);
        eq("R8 csw off", csw_log[(d0 + 2) & 63], 32'h00);
        eq("R8 tar fixed", tar_log[(d0 + 2) & 63], 32'h33);
        eq("R4 lane3", wd_log[(d0 + 2) & 63], 32'hA2000000);
        eq("R8 mem last", mem[8'h33], 8'hA2);
        eq("R8 mem next", mem[8'h34], 8'h6F);
    endtask

    task automatic t_boundary();
        load_src(6);
        run_cmd(32'd62, 3'd1, 6, 1, 1);
        eq("R7 drw count", drw_cnt - d0, 3);
        eq("R7 csw0", csw_log[d0 & 63], 32'h10);
        eq("R7 csw1", csw_log[(d0 + 1) & 63], 32'h10);
        eq("R7 csw2", csw_log[(d0 + 2) & 63], 32'h20);
        eq("R7 tar2", tar_log[(d0 + 2) & 63], 32'd64);
        for (int i = 0; i < 6; i++) eq("R7 mem", mem[62 + i], 8'hA0 + 8'(i));
    endtask

    task automatic t_reject();
        run_cmd(32'h02, 3'd4, 2, 0, 1);
        eq("R2 word misaligned", status, 1);
        eq("R2 no access", drw_cnt - d0, 0);
        run_cmd(32'h03, 3'd2, 2, 1, 1);
        eq("R2 half misaligned", status, 1);
        run_cmd(32'h00, 3'd3, 2, 0, 1);
        eq("R1 size 3", status, 1);
        eq("R1 no access", drw_cnt - d0, 0);
        run_cmd(32'h00, 3'd4, 0, 0, 1);
        eq("R10 zero status", status, 0);
        eq("R10 zero bytes", xfer_bytes, 0);
        eq("R10 zero access", drw_cnt - d0, 0);
    endtask

    task automatic t_bus_err();
        @(negedge clk); err_en = 1; err_tar = 32'h88; tb_over = 0;
        run_cmd(32'h80, 3'd4, 4, 0, 1);
        eq("R11 status", status, 2);
        eq("R11 fail addr", fail_addr, 32'h88);
        eq("R11 bytes", xfer_bytes, 8);
        eq("R11 sink", snk_cnt - s0, 8);
        eq("R11 drw tries", drw_cnt - d0, 3);
        @(negedge clk); tb_over = 1; tb_val = 32'h84;
        run_cmd(32'h80, 3'd4, 4, 0, 1);
        eq("R11 fail clipped", fail_addr, 32'h84);
        eq("R11 bytes clipped", xfer_bytes, 4);
        @(negedge clk); err_en = 0; tb_over = 0;
    endtask

    task automatic t_starve();
        int t;
        load_src(3);
        @(negedge clk);
        d0 = drw_cnt;
        cmd_addr = 32'h90; cmd_size = 3'd4; cmd_count = 2;
        cmd_write = 1; cmd_incr = 1; cmd_valid = 1;
        @(negedge clk); cmd_valid = 0;
        repeat (20) @(negedge clk);
        eq("R12 stalled drw", drw_cnt - d0, 0);
        eq("R12 stalled done", done, 0);
        src_lim = 8;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        eq("R12 status", status, 0);
        for (int i = 0; i < 8; i++) eq("R12 mem", mem[8'h90 + i], 8'hA0 + 8'(i));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_word_write();
        t_byte_write();
        t_half_read();
        t_no_incr();
        t_boundary();
        t_reject();
        t_bus_err();
        t_starve();
        eq("R3 order total", order_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule